// File: doc/BRIEF.md
# Display Controller Command and Pixel-Data Front-End

This block sits behind a byte-wide serial receiver in a small display controller. Each received byte comes with a select line. With the select line low the byte belongs to the command stream. The block picks out an opcode, takes the number of argument bytes that opcode needs, and applies the two commands that set the drawing window. With the select line high the byte is pixel data, two 4-bit pixels packed into one byte. It is written straight into the frame memory at the current cursor. The cursor then steps through the window and wraps back to the window's first column and first row.

Settings for the analog side and the image (brightness, drive current, timing, remapping, grey-scale tables) are accepted with the right number of argument bytes, and then dropped. An opcode the block does not know raises a one-cycle error pulse, and the next command byte is taken as a fresh opcode. A dirty flag tells the display-refresh side that the frame memory has changed. That side clears the flag with a one-cycle acknowledge.

The frame memory is 64 bytes wide and 80 rows deep, so it holds 5120 bytes. The write port runs in the same cycle as the data byte. The cursor and window registers move on the clock edge that ends that cycle.

Top module: `oledfe_top`

## Requirements
- R1: When `in_valid` is high and `in_is_data` is 1, `fb_we` is high in that same cycle and `fb_wdata` equals `in_byte`. When `in_is_data` is 0, or when `in_valid` is low, `fb_we` stays low.
- R2: The write address is row*64 + column, taken from the cursor as it stands before the byte is written. After reset the cursor is at column 0, row 0.
- R3: After each data byte the column goes up by one. If the new column is greater than the window's last column, the column returns to the window's first column and the row goes up by one.
- R4: After the step in R3, if the row is greater than the window's last row, the row returns to the window's first row.
- R5: Opcode 0x15 takes two argument bytes. They become the first and last column, each taken modulo 64. Opcode 0x75 takes two argument bytes. They become the first and last row, each taken modulo 80. The new window takes effect once the second argument byte has been received.
- R6: Opcodes 0x81, 0xA0, 0xA1, 0xA2, 0xA8, 0xAD, 0xB1, 0xB2, 0xB3, 0xBC, 0xBE and 0xBF each take one argument byte. Opcode 0xB8 takes eight. Argument bytes are never decoded as opcodes and never raise `bad_cmd`.
- R7: Opcodes 0x84, 0x85, 0x86, 0xA4 to 0xA7, 0xAE, 0xAF and 0xE3 are complete on the opcode byte, so the next command byte is an opcode.
- R8: After reset the window covers columns 0 to 63 and rows 0 to 79, `dirty` is 0 and no command is in progress.
- R9: A command byte that arrives in opcode position and is not listed in R5 to R7 makes `bad_cmd` high for that one cycle. The next command byte is taken as an opcode.
- R10: `dirty` becomes 1 on the cycle after any data byte. It becomes 0 on the cycle after a `redraw_ack` pulse that has no data byte in the same cycle. If a data byte and the acknowledge arrive together, the data byte wins.
- R11: Setting a window does not move the cursor. The cursor enters the new window only when the walk wraps as in R3 and R4. Command bytes and idle cycles leave the cursor unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A byte is present this cycle |
| in_is_data | input | 1 | 1: pixel data, 0: command stream |
| in_byte | input | 8 | The received byte |
| redraw_ack | input | 1 | One-cycle pulse from the refresh side that clears `dirty` |
| fb_we | output | 1 | Frame memory write enable |
| fb_addr | output | 13 | Frame memory byte address |
| fb_wdata | output | 8 | Frame memory write data |
| dirty | output | 1 | The frame memory has changed since the last acknowledge |
| bad_cmd | output | 1 | One-cycle pulse for an unrecognised opcode |

## Verification
The walk is tried in three settings. The first is the full reset window. The second is a narrow window set while the cursor is outside it, which tells "jump at once" apart from "enter on wrap". The third is a window whose arguments exceed 64 and 80, which shows whether the modulo reduction is done. Command streams mix zero-, one- and eight-argument opcodes, with argument values that would be unknown or window opcodes if they were decoded. This shows whether the argument counter consumes exactly the right number of bytes. A data byte placed inside a command still in progress, an unknown opcode followed by a window command, and data bytes that coincide with acknowledges cover the remaining orderings.

// File: rtl/oledfe_pkg.sv
// Shared constants and opcode classification for the display front-end.
// Assumes opcodes are 8 bits wide and that no opcode takes more than 8 argument bytes.
package oledfe_pkg;
    localparam logic [7:0] OP_COL_WIN = 8'h15;
    localparam logic [7:0] OP_ROW_WIN = 8'h75;

    typedef struct packed {
        logic       known;
        logic [3:0] nargs;
    } op_info_t;

    // Maps an opcode to "recognised" and its argument-byte count.
    function automatic op_info_t classify(input logic [7:0] op);
        op_info_t r;
        r.known = 1'b1;
        r.nargs = 4'd0;
        case (op)
            8'h15, 8'h75:                                   r.nargs = 4'd2;
            8'h81, 8'hA0, 8'hA1, 8'hA2, 8'hA8, 8'hAD,
            8'hB1, 8'hB2, 8'hB3, 8'hBC, 8'hBE, 8'hBF:       r.nargs = 4'd1;
            8'hB8:                                          r.nargs = 4'd8;
            8'h84, 8'h85, 8'h86, 8'hA4, 8'hA5, 8'hA6,
            8'hA7, 8'hAE, 8'hAF, 8'hE3:                     r.nargs = 4'd0;
            default:                                        r.known = 1'b0;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/oledfe_cmd_decode.sv
// Command-stream decoder: counts argument bytes per opcode and holds the
// drawing window. Assumes cmd_valid is already qualified by the select line.
module oledfe_cmd_decode
    import oledfe_pkg::*;
#(
    parameter int COLS = 64,
    parameter int ROWS = 80,
    localparam int COL_W = $clog2(COLS),
    localparam int ROW_W = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [7:0]       cmd_byte,
    output logic [COL_W-1:0] col_first,
    output logic [COL_W-1:0] col_last,
    output logic [ROW_W-1:0] row_first,
    output logic [ROW_W-1:0] row_last,
    output logic             bad_cmd
);
    logic [3:0] arg_cnt;
    logic [7:0] cur_op;
    logic [7:0] arg0;
    op_info_t   info;
    logic       in_op_pos;

    // Classify the new opcode or the one being collected.
    always_comb begin
        in_op_pos = (arg_cnt == 4'd0);
        info      = classify(in_op_pos ? cmd_byte : cur_op);
        bad_cmd   = cmd_valid && in_op_pos && !info.known;
    end

    // Argument counting and window register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arg_cnt   <= '0;
            cur_op    <= '0;
            arg0      <= '0;
            col_first <= '0;
            col_last  <= COL_W'(COLS - 1);
            row_first <= '0;
            row_last  <= ROW_W'(ROWS - 1);
        end else if (cmd_valid) begin
            if (in_op_pos) begin
                if (info.known && info.nargs != 4'd0) begin
                    cur_op  <= cmd_byte;
                    arg_cnt <= 4'd1;
                end
            end else begin
                if (arg_cnt == 4'd1) arg0 <= cmd_byte;
                if (arg_cnt == info.nargs) begin
                    arg_cnt <= '0;
                    if (cur_op == OP_COL_WIN) begin
                        col_first <= COL_W'(32'(arg0) % COLS);
                        col_last  <= COL_W'(32'(cmd_byte) % COLS);
                    end else if (cur_op == OP_ROW_WIN) begin
                        row_first <= ROW_W'(32'(arg0) % ROWS);
                        row_last  <= ROW_W'(32'(cmd_byte) % ROWS);
                    end
                end else begin
                    arg_cnt <= arg_cnt + 4'd1;
                end
            end
        end
    end

    assert_bad_resets_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bad_cmd |=> arg_cnt == 4'd0);
    assert_args_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
        arg_cnt <= 4'd8);
    assert_idle_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> $stable(arg_cnt) && $stable(col_first) && $stable(row_last));
endmodule

// File: rtl/oledfe_addr_walk.sv
// Cursor walker: steps the column/row cursor through the window after each
// data byte. Assumes window values are already reduced into range.
module oledfe_addr_walk #(
    parameter int COLS = 64,
    parameter int ROWS = 80,
    localparam int COL_W = $clog2(COLS),
    localparam int ROW_W = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic [COL_W-1:0] col_first,
    input  logic [COL_W-1:0] col_last,
    input  logic [ROW_W-1:0] row_first,
    input  logic [ROW_W-1:0] row_last,
    output logic [COL_W-1:0] col,
    output logic [ROW_W-1:0] row
);
    logic [COL_W:0] col_inc;
    logic [ROW_W:0] row_inc;
    logic           col_wrap;
    logic           row_wrap;

    // Next-cursor arithmetic with overflow detection.
    always_comb begin
        col_inc  = {1'b0, col} + 1'b1;
        col_wrap = col_inc > {1'b0, col_last};
        row_inc  = {1'b0, row} + {{ROW_W{1'b0}}, col_wrap};
        row_wrap = row_inc > {1'b0, row_last};
    end

    // Cursor register, advanced only by data bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col <= '0;
            row <= '0;
        end else if (step) begin
            col <= col_wrap ? col_first : col_inc[COL_W-1:0];
            row <= row_wrap ? row_first : row_inc[ROW_W-1:0];
        end
    end

    assert_col_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        step && !col_wrap |=> col == $past(col) + 1'b1);
    assert_row_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        step && row_wrap |=> row == $past(row_first));
    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(col) && $stable(row));
endmodule

// File: rtl/oledfe_dirty.sv
// Dirty flag: set by a frame write, cleared by an acknowledge; a write wins.
module oledfe_dirty (
    input  logic clk,
    input  logic rst_n,
    input  logic wr,
    input  logic ack,
    output logic dirty
);
    // Set/clear register with write priority.
    always_ff @(posedge clk) begin
        if (!rst_n)   dirty <= 1'b0;
        else if (wr)  dirty <= 1'b1;
        else if (ack) dirty <= 1'b0;
    end

    assert_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> dirty);
    assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ack && !wr |=> !dirty);
endmodule

// File: rtl/oledfe_top.sv
// Display front-end top: splits bytes by the select line, drives the frame
// memory write port from the cursor, and ties the decoder, walker and flag.
// Assumes at most one byte per cycle from an upstream deserialiser.
module oledfe_top #(
    parameter int COLS = 64,
    parameter int ROWS = 80,
    localparam int COL_W  = $clog2(COLS),
    localparam int ROW_W  = $clog2(ROWS),
    localparam int ADDR_W = $clog2(COLS * ROWS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_is_data,
    input  logic [7:0]        in_byte,
    input  logic              redraw_ack,
    output logic              fb_we,
    output logic [ADDR_W-1:0] fb_addr,
    output logic [7:0]        fb_wdata,
    output logic              dirty,
    output logic              bad_cmd
);
    logic             cmd_valid;
    logic [COL_W-1:0] col_first, col_last, col;
    logic [ROW_W-1:0] row_first, row_last, row;

    // Byte steering and write-port formation.
    always_comb begin
        fb_we     = in_valid && in_is_data;
        cmd_valid = in_valid && !in_is_data;
        fb_wdata  = in_byte;
        fb_addr   = ADDR_W'(row) * ADDR_W'(COLS) + ADDR_W'(col);
    end

    oledfe_cmd_decode #(.COLS(COLS), .ROWS(ROWS)) u_dec (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(in_byte),
        .col_first(col_first), .col_last(col_last),
        .row_first(row_first), .row_last(row_last), .bad_cmd(bad_cmd));

    oledfe_addr_walk #(.COLS(COLS), .ROWS(ROWS)) u_walk (
        .clk(clk), .rst_n(rst_n), .step(fb_we),
        .col_first(col_first), .col_last(col_last),
        .row_first(row_first), .row_last(row_last), .col(col), .row(row));

    oledfe_dirty u_dirty (
        .clk(clk), .rst_n(rst_n), .wr(fb_we), .ack(redraw_ack), .dirty(dirty));

    assert_cmd_no_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        bad_cmd |-> !fb_we);
    assert_addr_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fb_addr < ADDR_W'(COLS * ROWS));
endmodule

// File: tb/oledfe_top_tb_top.sv
`timescale 1ns/1ps
module oledfe_top_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_is_data = 1'b0, redraw_ack = 1'b0;
    logic [7:0] in_byte = '0;
    logic fb_we, dirty, bad_cmd;
    logic [12:0] fb_addr;
    logic [7:0] fb_wdata;

    always #4 clk = ~clk;

    oledfe_top dut_i (.clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_is_data(in_is_data), .in_byte(in_byte), .redraw_ack(redraw_ack),
        .fb_we(fb_we), .fb_addr(fb_addr), .fb_wdata(fb_wdata),
        .dirty(dirty), .bad_cmd(bad_cmd));

    int n_cmp = 0, n_bad = 0;
    bit done = 0;
    string tag = "R8";

    // Behavioural reference state
    int m_cs = 0, m_ce = 63, m_rs = 0, m_re = 79, m_col = 0, m_row = 0;
    int m_cnt = 0, m_op = 0, m_p0 = 0;
    bit m_dirty = 0;

    function automatic int nargs(int op);
        case (op)
            'h15, 'h75: return 2;
            'hB8: return 8;
            'h81, 'hA0, 'hA1, 'hA2, 'hA8, 'hAD, 'hB1, 'hB2, 'hB3, 'hBC, 'hBE, 'hBF: return 1;
            'h84, 'h85, 'h86, 'hA4, 'hA5, 'hA6, 'hA7, 'hAE, 'hAF, 'hE3: return 0;
            default: return -1;
        endcase
    endfunction

    task automatic cmp(string what, int got, int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s got %0h expected %0h", tag, what, got, exp);
        end
    endtask

    task automatic step(bit v, bit sel, int d, bit ack);
        bit exp_we, exp_bad;
        @(negedge clk);
        in_valid = v; in_is_data = sel; in_byte = 8'(d); redraw_ack = ack;
        #2;
        exp_we  = v && sel;
        exp_bad = v && !sel && m_cnt == 0 && nargs(d) < 0;
        cmp("fb_we", int'(fb_we), int'(exp_we));
        if (exp_we) begin
            cmp("fb_addr", int'(fb_addr), m_row * 64 + m_col);
            cmp("fb_wdata", int'(fb_wdata), d);
        end
        cmp("bad_cmd", int'(bad_cmd), int'(exp_bad));
        cmp("dirty", int'(dirty), int'(m_dirty));
        if (exp_we) begin
            m_col++;
            if (m_col > m_ce) begin m_col = m_cs; m_row++; end
            if (m_row > m_re) m_row = m_rs;
            m_dirty = 1;
        end else if (ack) m_dirty = 0;
        if (v && !sel) begin
            if (m_cnt == 0) begin
                if (nargs(d) > 0) begin m_op = d; m_cnt = 1; end
            end else begin
                if (m_cnt == 1) m_p0 = d;
                if (m_cnt == nargs(m_op)) begin
                    if (m_op == 'h15) begin m_cs = m_p0 % 64; m_ce = d % 64; end
                    if (m_op == 'h75) begin m_rs = m_p0 % 80; m_re = d % 80; end
                    m_cnt = 0;
                end else m_cnt++;
            end
        end
    endtask

    task automatic cmd(int d);  step(1, 0, d, 0); endtask
    task automatic dat(int d);  step(1, 1, d, 0); endtask
    task automatic idle(); step(0, 0, 0, 0); endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        tag = "R8"; idle(); idle();
        tag = "R1"; step(0, 1, 'h55, 0); dat('h12); dat('h34);
        tag = "R2"; for (int i = 0; i < 70; i++) dat(i);
        tag = "R10"; step(0, 0, 0, 1); idle(); dat('hAA); step(1, 1, 'hBB, 1); idle();
        step(0, 0, 0, 1); idle();
        tag = "R5"; cmd('h15); cmd('h42); cmd('h45);
        cmd('h75); cmd('h51); cmd('hA2);
        tag = "R11"; idle(); dat('h01); dat('h02);
        tag = "R3"; for (int i = 0; i < 40; i++) dat(i + 3);
        tag = "R4"; for (int i = 0; i < 10; i++) dat(i);
        tag = "R7"; cmd('hA4); cmd('hAE); cmd('hE3); cmd('h84); cmd('hAF);
        cmd('h15); cmd(0); cmd(3); dat(9); dat(8);
        tag = "R6"; cmd('h81); cmd('h00); cmd('hA0); cmd('h15);
        cmd('hB8); for (int i = 0; i < 8; i++) cmd('hFF - i);
        cmd('h75); cmd(2); cmd(3); for (int i = 0; i < 12; i++) dat(i);
        tag = "R9"; cmd('h00); cmd('h15); cmd(10); cmd(12); cmd('hFF); idle();
        for (int i = 0; i < 6; i++) dat(i);
        tag = "R11"; cmd('h75); cmd(0); dat('h77); cmd(79); dat('h66);
        for (int i = 0; i < 10; i++) dat(i);
        tag = "R2"; cmd('h15); cmd(0); cmd(63); cmd('h75); cmd(0); cmd(79);
        for (int i = 0; i < 200; i++) dat(i);
        idle();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired, got hang expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule